// File: doc/BRIEF.md
# Banked CPU Address Space Decoder

This block sits between a CPU with a 24-bit byte address bus and five possible targets. Each bank is 64 KB. The block splits every access into one of five regions: a mirrored window of work RAM, the system I/O registers, a coprocessor register window, banked cartridge ROM, or open bus. The region is chosen combinationally from the in-bank offset and from address bit 22. Address bit 23 is ignored for region choice, so the upper half of the space repeats the lower half.

For each access the block drives a one-hot region select. It also drives the translated addresses the targets need, and a write-forward strobe for the regions that accept writes. The read data of the chosen target is latched into a registered read-data output.

ROM addresses come from a 256-entry page table, indexed by the full 8-bit bank number. Each entry names a 32 KB ROM page. The table is loaded through a separate configuration port.

Open-bus reads return the last byte seen on the data bus, whether that byte was read or written.

Top module: `bank_decoder`

## Requirements
- R1: With address bit 22 clear and in-bank offset (bits 15:0) below 0x2000, the work-RAM select is asserted and `wram_addr` equals 0x7E0000 plus the offset.
- R2: With address bit 22 clear and offset in 0x2000..0x5FFF, the I/O select is asserted and `periph_addr` equals the offset.
- R3: With address bit 22 clear and offset in 0x6000..0x7FFF, the coprocessor select is asserted and `periph_addr` equals the offset.
- R4: In any bank, an offset of 0x8000 or more asserts the ROM select. `rom_addr` then equals page_table[address bits 23:16] × 0x8000 + (offset & 0x7FFF).
- R5: With address bit 22 set and offset below 0x8000, the open-bus select is asserted. A read there returns the last data byte of the most recent completed access: the read result for a read, the write data for a write. Both the bus byte and `cpu_rdata` are 0 after reset.
- R6: Address bit 23 has no effect on region choice or on translated RAM and peripheral addresses. Only the page-table index uses it.
- R7: `wr_fwd` is high exactly when a write decodes to work RAM, I/O or the coprocessor window. Writes that decode to ROM or open bus are dropped.
- R8: While `cpu_rd` or `cpu_wr` is high, exactly one of the five selects is high. While neither is high, all five are low.
- R9: `cpu_rdata` takes the selected region's data at the clock edge that ends a read cycle. It is visible after that edge and holds its value while no read is made.
- R10: All page-table entries are 0 after reset. A configuration write (`cfg_we`) updates entry `cfg_idx` only in a cycle with no CPU strobe. It is ignored while `cpu_rd` or `cpu_wr` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 24 | CPU byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| sel_wram | output | 1 | Work-RAM region select |
| sel_io | output | 1 | I/O register region select |
| sel_cop | output | 1 | Coprocessor window select |
| sel_rom | output | 1 | ROM region select |
| sel_open | output | 1 | Open-bus region select |
| wr_fwd | output | 1 | Write forwarded to the selected target |
| wram_addr | output | 24 | Translated work-RAM address |
| periph_addr | output | 16 | In-bank offset for I/O and coprocessor |
| rom_addr | output | 23 | Translated ROM byte address |
| wram_rdata | input | 8 | Work-RAM read data |
| io_rdata | input | 8 | I/O register read data |
| cop_rdata | input | 8 | Coprocessor read data |
| rom_rdata | input | 8 | ROM read data |
| cfg_we | input | 1 | Page-table write enable |
| cfg_idx | input | 8 | Page-table entry index |
| cfg_data | input | 8 | Page-table entry value |

## Verification
The bench builds the block with its default parameters: an 8-bit page entry, which makes the ROM address 23 bits wide, and a work-RAM base of 0x7E0000.

With 8-bit entries, random page values reach every ROM address bit. Random addresses across all 256 banks therefore reach both halves of the space and the area with bit 22 set. Directed accesses sit on each region boundary and on a bank whose index differs only in bit 23.

The bench also checks the open-bus byte after a run of mixed reads and writes. It checks a page-table write that collides with a CPU strobe, and the read-data hold across write and idle cycles.

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int          DATA_W    = 8,
  parameter int          PAGE_W    = 8,
  parameter logic [23:0] WRAM_BASE = 24'h7E0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [23:0]       cpu_addr,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              sel_wram,
  output logic              sel_io,
  output logic              sel_cop,
  output logic              sel_rom,
  output logic              sel_open,
  output logic              wr_fwd,
  output logic [23:0]       wram_addr,
  output logic [15:0]       periph_addr,
  output logic [PAGE_W+14:0] rom_addr,
  input  logic [DATA_W-1:0] wram_rdata,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] cop_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_idx,
  input  logic [PAGE_W-1:0] cfg_data
);
  localparam int BANKS = 256;

  logic [PAGE_W-1:0] page_tbl [BANKS];
  logic [DATA_W-1:0] bus_q;
  logic [DATA_W-1:0] rd_mux;
  logic [15:0]       ofs;
  logic              strobe, low_area;

  assign ofs      = cpu_addr[15:0];
  assign strobe   = cpu_rd | cpu_wr;
  assign low_area = strobe & ~ofs[15] & ~cpu_addr[22];

  assign sel_rom  = strobe & ofs[15];
  assign sel_open = strobe & ~ofs[15] & cpu_addr[22];
  assign sel_wram = low_area & (ofs[14:13] == 2'b00);
  assign sel_io   = low_area & (ofs[14] ^ ofs[13]);
  assign sel_cop  = low_area & (ofs[14:13] == 2'b11);
  assign wr_fwd   = cpu_wr & (sel_wram | sel_io | sel_cop);

  assign wram_addr   = WRAM_BASE + {11'd0, ofs[12:0]};
  assign periph_addr = ofs;
  assign rom_addr    = {page_tbl[cpu_addr[23:16]], ofs[14:0]};

  always_comb begin
    if (sel_rom)       rd_mux = rom_rdata;
    else if (sel_wram) rd_mux = wram_rdata;
    else if (sel_io)   rd_mux = io_rdata;
    else if (sel_cop)  rd_mux = cop_rdata;
    else               rd_mux = bus_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BANKS; i++) page_tbl[i] <= '0;
    end else if (cfg_we && !strobe) begin
      page_tbl[cfg_idx] <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_rdata <= '0;
      bus_q     <= '0;
    end else if (cpu_wr) begin
      bus_q     <= cpu_wdata;
    end else if (cpu_rd) begin
      cpu_rdata <= rd_mux;
      bus_q     <= rd_mux;
    end
  end

  p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> $onehot({sel_wram, sel_io, sel_cop, sel_rom, sel_open}));

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> ({sel_wram, sel_io, sel_cop, sel_rom, sel_open} == 5'b0));

  p_wr_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rom || sel_open) |-> !wr_fwd);

  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_rd |=> $stable(cpu_rdata));

  p_open_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !cpu_wr && sel_open) |=> (cpu_rdata == $past(bus_q)));

  p_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wram |-> (wram_addr[23:13] == WRAM_BASE[23:13]));
endmodule

// File: tb/bank_decoder_tb.sv
module bank_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic sel_wram, sel_io, sel_cop, sel_rom, sel_open, wr_fwd;
  logic [23:0] wram_addr;
  logic [15:0] periph_addr;
  logic [22:0] rom_addr;
  logic [7:0] wram_rdata, io_rdata, cop_rdata, rom_rdata;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_idx = '0, cfg_data = '0;

  int n_tests = 0, n_fail = 0;
  logic [7:0] ref_tbl [256];
  logic [7:0] ref_bus, ref_rdata;

  always #10 clk = ~clk;

  assign wram_rdata = wram_addr[7:0] ^ wram_addr[23:16];
  assign io_rdata   = periph_addr[7:0] ^ 8'h22;
  assign cop_rdata  = periph_addr[7:0] ^ 8'h33;
  assign rom_rdata  = rom_addr[7:0] ^ rom_addr[22:15];

  bank_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sel_wram(sel_wram), .sel_io(sel_io),
    .sel_cop(sel_cop), .sel_rom(sel_rom), .sel_open(sel_open), .wr_fwd(wr_fwd),
    .wram_addr(wram_addr), .periph_addr(periph_addr), .rom_addr(rom_addr),
    .wram_rdata(wram_rdata), .io_rdata(io_rdata), .cop_rdata(cop_rdata),
    .rom_rdata(rom_rdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data));

  // region codes: 0 wram, 1 io, 2 cop, 3 rom, 4 open
  function automatic int exp_region(input logic [23:0] a);
    if (a[15]) return 3;
    if (a[22]) return 4;
    if (a[15:0] < 16'h2000) return 0;
    if (a[15:0] < 16'h6000) return 1;
    return 2;
  endfunction

  function automatic logic [22:0] exp_rom(input logic [23:0] a);
    return {ref_tbl[a[23:16]], 15'd0} + {8'd0, a[14:0]};
  endfunction

  function automatic logic [7:0] exp_data(input logic [23:0] a);
    logic [22:0] ra;
    logic [23:0] wa;
    case (exp_region(a))
      0: begin wa = 24'h7E0000 + {8'd0, a[15:0]}; return wa[7:0] ^ wa[23:16]; end
      1: return a[7:0] ^ 8'h22;
      2: return a[7:0] ^ 8'h33;
      3: begin ra = exp_rom(a); return ra[7:0] ^ ra[22:15]; end
      default: return ref_bus;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input bit wr, input logic [7:0] wd);
    int r;
    logic [4:0] sels;
    @(negedge clk);
    cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = wd;
    #2;
    r = exp_region(a);
    sels = {sel_open, sel_rom, sel_cop, sel_io, sel_wram};
    check("R8 select onehot/region", {27'd0, sels}, 32'd1 << r);
    check("R7 wr_fwd", {31'd0, wr_fwd}, {31'd0, wr && r < 3});
    case (r)
      0: check("R1 wram_addr", {8'd0, wram_addr}, {8'd0, 24'h7E0000 + {11'd0, a[12:0]}});
      1: check("R2 periph_addr io", {16'd0, periph_addr}, {16'd0, a[15:0]});
      2: check("R3 periph_addr cop", {16'd0, periph_addr}, {16'd0, a[15:0]});
      3: check("R4 rom_addr", {9'd0, rom_addr}, {9'd0, exp_rom(a)});
      default: ;
    endcase
    if (!wr) ref_rdata = exp_data(a);
    @(posedge clk); #1;
    if (wr) ref_bus = wd; else ref_bus = ref_rdata;
    check(wr ? "R9 rdata held on write" : "R9/R5 read data", {24'd0, cpu_rdata}, {24'd0, ref_rdata});
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    ref_tbl[idx] = d;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) ref_tbl[i] = 8'h00;
    ref_bus = 8'h00; ref_rdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    check("R8 idle selects after reset", {27'd0, sel_open, sel_rom, sel_cop, sel_io, sel_wram}, 32'd0);
    check("R9 rdata reset", {24'd0, cpu_rdata}, 32'd0);

    // R5: open bus right after reset returns 0
    access(24'h400010, 1'b0, 8'h00);
    // R10: reset table value 0
    access(24'h05_8123, 1'b0, 8'h00);
    // region boundaries R1 R2 R3 R4
    access(24'h001FFF, 1'b0, 8'h00);
    access(24'h002000, 1'b0, 8'h00);
    access(24'h005FFF, 1'b0, 8'h00);
    access(24'h006000, 1'b0, 8'h00);
    access(24'h007FFF, 1'b0, 8'h00);
    access(24'h008000, 1'b0, 8'h00);
    access(24'h3F7FFF, 1'b0, 8'h00);
    access(24'h400000, 1'b0, 8'h00);
    // R6 upper half mirror
    access(24'h801234, 1'b0, 8'h00);
    access(24'hC07000, 1'b0, 8'h00);
    cfg_write(8'h83, 8'hA5);
    cfg_write(8'h03, 8'h11);
    access(24'h83_9000, 1'b0, 8'h00);
    access(24'h03_9000, 1'b0, 8'h00);
    // R5 open bus after a write; R7 write to rom dropped
    access(24'h00_9000, 1'b1, 8'h6C);
    access(24'h41_0000, 1'b0, 8'h00);
    access(24'h00_0100, 1'b1, 8'h3E);
    access(24'hC1_2000, 1'b0, 8'h00);
    // R10: cfg write during strobe is ignored
    @(negedge clk);
    cpu_addr = 24'h02_0000; cpu_rd = 1'b1; cfg_we = 1'b1; cfg_idx = 8'h07; cfg_data = 8'hEE;
    @(negedge clk);
    cpu_rd = 1'b0; cfg_we = 1'b0;
    ref_bus = exp_data(24'h02_0000); ref_rdata = ref_bus;
    access(24'h07_8001, 1'b0, 8'h00);
    check("R10 cfg ignored while busy", {9'd0, rom_addr}, {9'd0, exp_rom(24'h07_8001)});

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'h0) cfg_write(r[15:8], r[23:16]);
      else access($urandom, r[4] & r[5], r[31:24]);
      if (r[9:6] == 4'h0) begin
        @(negedge clk); #2;
        check("R8 idle none selected", {27'd0, sel_open, sel_rom, sel_cop, sel_io, sel_wram}, 32'd0);
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule